// File: doc/BRIEF.md
# TLB Maintenance Operation Decoder

This block sits between the register-write path of a processor cluster and the translation caches of its cores. A maintenance write carries a 4-bit operation code and a 32-bit data word. The block turns it into an invalidate command that says which kind of invalidation to do, which of the two translation caches (instruction side, data side) it applies to, and the page address and address-space identifier taken from the data word.

Operations of local scope produce one command for the core that issued the write. Operations of broadcast scope produce one command per core, in ascending core order, over a valid/ready channel. While a command sequence is in flight, the block reports busy and refuses further writes by holding its write-ready output low. The caches themselves are outside the block.

Top module: `tlb_maint_dec`

## Requirements
- R1: After reset, `busy` and `cmd_valid` are 0 and `wr_ready` is 1.
- R2: Opcodes 0 to 7 have broadcast scope and drive both `cmd_itlb` and `cmd_dtlb` to 1. Bit 0 of these opcodes is a shareability hint and has no effect. Opcodes 8 to 13 have local scope. For those, an even opcode selects the instruction side only and an odd opcode selects the data side only.
- R3: For the two address-based kinds, `cmd_addr` is data bits 31:12 followed by twelve zero bits. For the other kinds it is 0.
- R4: For by-address-plus-ASID and by-ASID, `cmd_asid` is data bits 7:0. For invalidate-all and by-address-all-ASID it is 0, so by-address-all-ASID ignores the low data byte.
- R5: A broadcast write issues one command to each core from 0 to N_CORES-1 in ascending order. The next core is presented only after the current one has been accepted, and `cmd_bcast` is 1 throughout.
- R6: A local write issues exactly one command, with `cmd_core` equal to `wr_src` and `cmd_bcast` equal to 0.
- R7: A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. From the next cycle, `busy` is 1 and `wr_ready` is 0. `busy` returns to 0 in the cycle after the last command of the sequence is accepted.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, every command output holds its value.
- R9: Opcodes 14 and 15 are reserved. A write carrying one of them is accepted, issues no command and leaves `busy` at 0.
- R10: `cmd_kind` is equal to opcode bits 2:1. The encodings are 0 for invalidate-all, 1 for by-address-plus-ASID, 2 for by-ASID and 3 for by-address-all-ASID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Maintenance write present |
| wr_op | input | 4 | Operation code |
| wr_data | input | 32 | Operation data word |
| wr_src | input | CORE_W | Index of the issuing core |
| wr_ready | output | 1 | Write can be accepted this cycle |
| busy | output | 1 | Command sequence in flight |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Target core accepts the command |
| cmd_core | output | CORE_W | Target core index |
| cmd_bcast | output | 1 | Command belongs to a broadcast sequence |
| cmd_kind | output | 2 | Invalidation kind |
| cmd_itlb | output | 1 | Apply to the instruction-side cache |
| cmd_dtlb | output | 1 | Apply to the data-side cache |
| cmd_addr | output | 32 | Page-aligned address |
| cmd_asid | output | 8 | Address-space identifier |

## Verification
The first command appears one cycle after the accepting edge, and `busy` rises in the same cycle. Each later broadcast command appears one cycle after the edge where the previous one was accepted. `busy` falls one cycle after the final acceptance. The bench sets inputs and reads outputs only on falling edges. It pops an expected command from its scoreboard at the falling edge that comes before each accepting rising edge. It checks the idle and hold conditions at the falling edge one cycle later. A pseudo-random `cmd_ready` pattern produces stalls of varied length, so the hold rule and the ascending core walk are exercised under back-pressure.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    localparam int MT_OP_W     = 4;
    localparam int MT_DATA_W   = 32;
    localparam int MT_PAGE_LSB = 12;
    localparam int MT_ASID_W   = 8;

    typedef enum logic [1:0] {
        MT_ALL      = 2'd0,
        MT_VA_ASID  = 2'd1,
        MT_ASID     = 2'd2,
        MT_VA_ANY   = 2'd3
    } mt_kind_e;

    typedef struct packed {
        logic                    ok;
        mt_kind_e                kind;
        logic                    itlb;
        logic                    dtlb;
        logic                    bcast;
        logic [MT_DATA_W-1:0]    addr;
        logic [MT_ASID_W-1:0]    asid;
    } mt_cmd_t;

    function automatic logic mt_uses_addr(mt_kind_e k);
        return (k == MT_VA_ASID) || (k == MT_VA_ANY);
    endfunction

    function automatic logic mt_uses_asid(mt_kind_e k);
        return (k == MT_VA_ASID) || (k == MT_ASID);
    endfunction

endpackage

// File: rtl/tlbm_decode.sv
module tlbm_decode
    import tlbm_pkg::*;
(
    input  logic [MT_OP_W-1:0]   op,
    input  logic [MT_DATA_W-1:0] data,
    output mt_cmd_t              cmd
);
    logic     local_op;
    logic     reserved;
    mt_kind_e kind;

    always_comb begin
        local_op = op[3];
        reserved = op[3] & op[2] & op[1];
        kind     = mt_kind_e'(op[2:1]);
        cmd      = '0;
        if (!reserved) begin
            cmd.ok    = 1'b1;
            cmd.kind  = kind;
            cmd.bcast = !local_op;
            cmd.itlb  = !local_op || !op[0];
            cmd.dtlb  = !local_op ||  op[0];
            if (mt_uses_addr(kind))
                cmd.addr = {data[MT_DATA_W-1:MT_PAGE_LSB], {MT_PAGE_LSB{1'b0}}};
            if (mt_uses_asid(kind))
                cmd.asid = data[MT_ASID_W-1:0];
        end
    end
endmodule

// File: rtl/tlbm_issue.sv
module tlbm_issue
    import tlbm_pkg::*;
#(
    parameter int N_CORES = 4,
    localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  mt_cmd_t           dec,
    input  logic [CORE_W-1:0] src,
    input  logic              out_ready,
    output logic              active,
    output mt_cmd_t           cur,
    output logic [CORE_W-1:0] core
);
    localparam logic [CORE_W-1:0] LAST_CORE = CORE_W'(N_CORES - 1);

    logic    active_q;
    mt_cmd_t cur_q;
    logic [CORE_W-1:0] core_q;
    logic    at_end;

    assign at_end = !cur_q.bcast || (core_q == LAST_CORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cur_q    <= '0;
            core_q   <= '0;
        end else if (!active_q) begin
            if (take && dec.ok) begin
                active_q <= 1'b1;
                cur_q    <= dec;
                core_q   <= dec.bcast ? '0 : src;
            end
        end else if (out_ready) begin
            if (at_end)
                active_q <= 1'b0;
            else
                core_q <= core_q + 1'b1;
        end
    end

    assign active = active_q;
    assign cur    = cur_q;
    assign core   = core_q;
endmodule

// File: rtl/tlb_maint_dec.sv
module tlb_maint_dec
    import tlbm_pkg::*;
#(
    parameter int N_CORES = 4,
    localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    input  logic [MT_OP_W-1:0]   wr_op,
    input  logic [MT_DATA_W-1:0] wr_data,
    input  logic [CORE_W-1:0]    wr_src,
    output logic                 wr_ready,
    output logic                 busy,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [CORE_W-1:0]    cmd_core,
    output logic                 cmd_bcast,
    output logic [1:0]           cmd_kind,
    output logic                 cmd_itlb,
    output logic                 cmd_dtlb,
    output logic [MT_DATA_W-1:0] cmd_addr,
    output logic [MT_ASID_W-1:0] cmd_asid
);
    mt_cmd_t dec_cmd;
    mt_cmd_t cur_cmd;
    logic    active;

    tlbm_decode u_dec (
        .op   (wr_op),
        .data (wr_data),
        .cmd  (dec_cmd)
    );

    tlbm_issue #(.N_CORES(N_CORES)) u_iss (
        .clk       (clk),
        .rst       (rst),
        .take      (wr_valid && wr_ready),
        .dec       (dec_cmd),
        .src       (wr_src),
        .out_ready (cmd_ready),
        .active    (active),
        .cur       (cur_cmd),
        .core      (cmd_core)
    );

    assign wr_ready  = !active;
    assign busy      = active;
    assign cmd_valid = active;
    assign cmd_bcast = cur_cmd.bcast;
    assign cmd_kind  = cur_cmd.kind;
    assign cmd_itlb  = cur_cmd.itlb;
    assign cmd_dtlb  = cur_cmd.dtlb;
    assign cmd_addr  = cur_cmd.addr;
    assign cmd_asid  = cur_cmd.asid;
endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker #(
    parameter int N_CORES = 4,
    localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic [3:0]        wr_op,
    input logic              wr_ready,
    input logic              busy,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [CORE_W-1:0] cmd_core,
    input logic              cmd_bcast,
    input logic [1:0]        cmd_kind,
    input logic              cmd_itlb,
    input logic              cmd_dtlb,
    input logic [31:0]       cmd_addr,
    input logic [7:0]        cmd_asid
);
    localparam logic [CORE_W-1:0] LAST = CORE_W'(N_CORES - 1);
    logic rsv;
    assign rsv = wr_op[3] & wr_op[2] & wr_op[1];

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_core) && $stable(cmd_kind)
            && $stable(cmd_addr) && $stable(cmd_asid) && $stable(cmd_itlb)
            && $stable(cmd_dtlb) && $stable(cmd_bcast));

    assert_start_R7: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_ready && !rsv |=> cmd_valid && busy && !wr_ready);

    assert_reserved_R9: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_ready && rsv |=> !busy && !cmd_valid);

    assert_page_zero_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_addr[11:0] == 12'h000);

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && cmd_bcast && cmd_core != LAST
            |=> cmd_valid && cmd_core == $past(cmd_core) + 1'b1);

    assert_first_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_valid) && cmd_bcast |-> cmd_core == '0);

    assert_done_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && (!cmd_bcast || cmd_core == LAST) |=> !busy && wr_ready);

    assert_sides_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_bcast ? (cmd_itlb && cmd_dtlb) : (cmd_itlb ^ cmd_dtlb)));
endmodule

bind tlb_maint_dec tlbm_checker #(.N_CORES(N_CORES)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_op(wr_op), .wr_ready(wr_ready),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_core(cmd_core),
    .cmd_bcast(cmd_bcast), .cmd_kind(cmd_kind), .cmd_itlb(cmd_itlb),
    .cmd_dtlb(cmd_dtlb), .cmd_addr(cmd_addr), .cmd_asid(cmd_asid)
);

// File: tb/tlb_maint_dec_tb.sv
module tlb_maint_dec_tb;
    localparam int N  = 4;
    localparam int CW = 2;

    typedef struct {
        int          core;
        logic [1:0]  kind;
        logic        i, d, b;
        logic [31:0] addr;
        logic [7:0]  asid;
        logic        last;
    } exp_t;

    logic clk = 0, rst = 1;
    logic wr_valid = 0;
    logic [3:0] wr_op = 0;
    logic [31:0] wr_data = 0;
    logic [CW-1:0] wr_src = 0;
    logic wr_ready, busy, cmd_valid;
    logic cmd_ready = 1;
    logic [CW-1:0] cmd_core;
    logic cmd_bcast, cmd_itlb, cmd_dtlb;
    logic [1:0] cmd_kind;
    logic [31:0] cmd_addr;
    logic [7:0] cmd_asid;

    int errors = 0, checks = 0, cycles = 0;
    exp_t q[$];
    logic stall_en = 0;
    logic [7:0] lfsr = 8'h5A;
    logic idle_chk = 0, hold_chk = 0;
    logic [63:0] snap;

    tlb_maint_dec #(.N_CORES(N)) u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_op(wr_op), .wr_data(wr_data),
        .wr_src(wr_src), .wr_ready(wr_ready), .busy(busy), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_core(cmd_core), .cmd_bcast(cmd_bcast),
        .cmd_kind(cmd_kind), .cmd_itlb(cmd_itlb), .cmd_dtlb(cmd_dtlb),
        .cmd_addr(cmd_addr), .cmd_asid(cmd_asid));

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pack_out();
        return {14'd0, cmd_core, cmd_kind, cmd_itlb, cmd_dtlb, cmd_bcast, cmd_asid, cmd_addr, 3'd0};
    endfunction

    // Expected commands from the requirements (R2, R3, R4, R6, R10)
    task automatic push_expected(input logic [3:0] op, input logic [31:0] data, input int src);
        exp_t e;
        logic [1:0] k;
        if (op[3] && op[2] && op[1]) return;
        k = op[2:1];
        e.kind = k;
        e.b    = !op[3];
        e.i    = !op[3] || !op[0];
        e.d    = !op[3] ||  op[0];
        e.addr = (k == 2'd1 || k == 2'd3) ? {data[31:12], 12'h000} : 32'h0;
        e.asid = (k == 2'd1 || k == 2'd2) ? data[7:0] : 8'h00;
        if (e.b) begin
            for (int c = 0; c < N; c++) begin
                e.core = c;
                e.last = (c == N - 1);
                q.push_back(e);
            end
        end else begin
            e.core = src;
            e.last = 1'b1;
            q.push_back(e);
        end
    endtask

    task automatic do_write(input logic [3:0] op, input logic [31:0] data, input int src);
        @(negedge clk);
        wr_valid = 1; wr_op = op; wr_data = data; wr_src = CW'(src);
        while (!wr_ready) @(negedge clk);
        push_expected(op, data, src);
        @(negedge clk);
        wr_valid = 0;
        if (op[3] && op[2] && op[1]) begin
            chk(!busy && !cmd_valid && wr_ready, "R9", {61'd0, busy, cmd_valid, wr_ready}, 64'h1);
        end else begin
            chk(busy && !wr_ready, "R7", {62'd0, busy, wr_ready}, 64'h2);
        end
    endtask

    // Monitor: scoreboard pop on each handshake (R5, R6, R2, R3, R4, R10), hold (R8), idle (R7)
    always @(negedge clk) begin
        if (!rst) begin
            cycles++;
            if (idle_chk) begin
                chk(!busy && wr_ready, "R7", {62'd0, busy, wr_ready}, 64'h1);
                idle_chk = 0;
            end
            if (hold_chk) begin
                chk(cmd_valid && pack_out() == snap, "R8", pack_out(), snap);
                hold_chk = 0;
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cmd_ready = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
            if (cmd_valid) begin
                if (cmd_ready) begin
                    if (q.size() == 0) begin
                        chk(0, "R9", pack_out(), 64'h0);
                    end else begin
                        exp_t e;
                        logic [63:0] ev;
                        e = q.pop_front();
                        ev = {14'd0, CW'(e.core), e.kind, e.i, e.d, e.b, e.asid, e.addr, 3'd0};
                        chk(pack_out() == ev, e.b ? "R5" : "R6", pack_out(), ev);
                        if (e.last) idle_chk = 1;
                    end
                end else begin
                    snap = pack_out();
                    hold_chk = 1;
                end
            end
        end
    end

    initial begin
        while (cycles < 100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(!busy && !cmd_valid && wr_ready, "R1", {61'd0, busy, cmd_valid, wr_ready}, 64'h1);

        do_write(4'd0, 32'hFFFF_FFFF, 1);  // R10 kind 0, broadcast, no fields
        do_write(4'd3, 32'h1234_5ABC, 0);  // R3 R4 address+ASID, R2 inner hint ignored
        do_write(4'd5, 32'hDEAD_BE77, 2);  // R4 ASID only
        do_write(4'd6, 32'hCAFE_F0AB, 3);  // R4 ASID ignored, R3 address
        stall_en = 1;
        do_write(4'd2, 32'h8000_1FFF, 0);  // R8 under stalls
        do_write(4'd8, 32'hAAAA_AAAA, 2);  // R6 local I-side all
        do_write(4'd11, 32'h0000_3011, 1); // R2 D-side, R3 R4
        do_write(4'd12, 32'h0F0F_0F5E, 3); // R2 I-side by ASID
        do_write(4'd13, 32'hFFFF_F001, 0); // R2 D-side by ASID
        do_write(4'd7, 32'h7654_3210, 2);  // R5 broadcast under stalls
        stall_en = 0;
        do_write(4'd14, 32'h1111_1111, 1); // R9 reserved
        do_write(4'd15, 32'h2222_2222, 0); // R9 reserved
        do_write(4'd9, 32'h0, 3);          // R6 local D-side all

        while (q.size() != 0 || busy) @(negedge clk);
        @(negedge clk);
        chk(q.size() == 0 && !busy && !cmd_valid, "R7", {62'd0, busy, cmd_valid}, 64'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule